// File: doc/BRIEF.md
# Bit-Field ALU with Staged Flip

This block is a purely combinational 32-bit arithmetic and logic unit. It has two operands and a 4-bit operation code. Operand A is a register value. Operand B is either a register value or an immediate that has already been sign-extended. Beyond addition, subtraction, the four bitwise logic functions, shifts and rotation, it offers four less common operations:

- a 10-bit immediate append, which shifts A up and fills the vacated bits from B;
- bit-field insert;
- signed and unsigned bit-field extract;
- a bit permutation ("flip") built from five swap stages.

For the field operations, the field position and length both arrive packed in the low bits of B. A zero length stands for a 16-bit field. An undefined operation code raises an illegal-operation flag. Operand fetch, register writeback and condition flags are handled by the surrounding datapath.

Top module: `bfalu`

## Requirements
- R1: Code 0 returns A+B and code 2 returns A-B, both modulo 2^32.
- R2: Code 4 returns A AND B, code 5 returns A OR B, code 6 returns A XOR B and code 7 returns the inverse of A XOR B.
- R3: Code 8 shifts A left, code 9 shifts A right logically and code 10 shifts A right arithmetically. The amount is B[4:0] and the upper bits of B are ignored.
- R4: Code 1 rotates A right by B[4:0]. Bits leaving bit 0 re-enter at bit 31, and the upper bits of B are ignored.
- R5: Code 3 returns A shifted left by 10, with B[9:0] placed in result bits [9:0].
- R6: For codes 11, 12 and 13 the field starts at bit B[4:0] and its length is B[8:5]. A length value of 0 selects 16 bits.
- R7: Code 11 writes the low bits of B[31:10] into A over the field. Every bit of A outside the field is kept, and field bits that would lie above bit 31 are dropped.
- R8: Code 12 takes the field out of A, moves it to bit 0 and copies its top bit into all higher result bits. Field bits above bit 31 of A read as zero.
- R9: Code 13 takes the same field out of A, moves it to bit 0 and clears all higher result bits.
- R10: Code 14 applies five swap stages to A, in this order, each enabled by one bit of B: B[0] swaps adjacent bits, B[1] swaps 2-bit pairs, B[2] swaps nibbles, B[3] swaps bytes and B[4] swaps 16-bit halves.
- R11: Code 15 raises the illegal flag and drives the result to zero. Every other code leaves the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 32 | Operand A |
| b | input | 32 | Operand B, register value or sign-extended immediate |
| op | input | 4 | Operation code |
| result | output | 32 | Operation result |
| illegal | output | 1 | High when the operation code is undefined |

## Verification
The block holds no state. Every result and the illegal flag are therefore due in the same cycle as the operands and code, after combinational settling only. The bench drives each new operand set on a falling clock edge and samples one nanosecond later, well before the next rising edge. Because of this, no check depends on edge ordering, and each check sees the response to exactly one stimulus.

// File: rtl/bfalu_pkg.sv
package bfalu_pkg;
   typedef enum logic [3:0] {
      OP_ADD  = 4'h0,
      OP_ROR  = 4'h1,
      OP_SUB  = 4'h2,
      OP_APND = 4'h3,
      OP_AND  = 4'h4,
      OP_OR   = 4'h5,
      OP_XOR  = 4'h6,
      OP_XNOR = 4'h7,
      OP_SLL  = 4'h8,
      OP_SRL  = 4'h9,
      OP_SRA  = 4'hA,
      OP_FINS = 4'hB,
      OP_FEXS = 4'hC,
      OP_FEXU = 4'hD,
      OP_FLIP = 4'hE,
      OP_BAD  = 4'hF
   } bfalu_op_e;

   typedef enum logic [2:0] {
      UNIT_ARITH,
      UNIT_SHIFT,
      UNIT_FIELD,
      UNIT_FLIP,
      UNIT_NONE
   } bfalu_unit_e;
endpackage

// File: rtl/bfalu_arith.sv
module bfalu_arith
   import bfalu_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  bfalu_op_e        op,
   output logic [WIDTH-1:0] res
);
   logic [WIDTH-1:0] sum_q;
   logic [WIDTH-1:0] diff_q;
   logic             do_sub;

   assign do_sub = (op == OP_SUB);

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [WIDTH-1:0] b_eff;
         logic [WIDTH-1:0] total;
         assign b_eff  = do_sub ? ~b : b;
         assign total  = a + b_eff + WIDTH'(do_sub);
         assign sum_q  = total;
         assign diff_q = total;
      end else begin : g_split
         assign sum_q  = a + b;
         assign diff_q = a - b;
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_ADD:  res = sum_q;
         OP_SUB:  res = diff_q;
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_XNOR: res = ~(a ^ b);
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/bfalu_shift.sv
module bfalu_shift
   import bfalu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int APPEND_W   = 10,
   parameter bit ROT_DOUBLE = 1'b1,
   localparam int AMT_W     = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0]    a,
   input  logic [AMT_W-1:0]    amt,
   input  logic [APPEND_W-1:0] imm,
   input  bfalu_op_e           op,
   output logic [WIDTH-1:0]    res
);
   logic [WIDTH-1:0] rot_q;
   logic [WIDTH-1:0] sra_q;
   logic [WIDTH-1:0] apnd_q;

   generate
      if (ROT_DOUBLE) begin : g_rot_dbl
         assign rot_q = WIDTH'({a, a} >> amt);
      end else begin : g_rot_or
         assign rot_q = (a >> amt) | (a << (WIDTH - int'(amt)));
      end
   endgenerate

   assign sra_q  = $unsigned($signed(a) >>> amt);
   assign apnd_q = {a[WIDTH-APPEND_W-1:0], imm};

   always_comb begin
      unique case (op)
         OP_ROR:  res = rot_q;
         OP_SLL:  res = a << amt;
         OP_SRL:  res = a >> amt;
         OP_SRA:  res = sra_q;
         OP_APND: res = apnd_q;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/bfalu_field.sv
module bfalu_field
   import bfalu_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int LEN_W     = 4,
   parameter int ZERO_LEN  = 16,
   parameter int INS_SHIFT = 10,
   localparam int POS_W    = $clog2(WIDTH),
   localparam int FLEN_W   = POS_W + 1,
   localparam int DESC_W   = POS_W + LEN_W,
   localparam int SRC_W    = WIDTH - INS_SHIFT
) (
   input  logic [WIDTH-1:0]  a,
   input  logic [DESC_W-1:0] desc,
   input  logic [SRC_W-1:0]  src,
   input  bfalu_op_e         op,
   output logic [WIDTH-1:0]  res
);
   logic [POS_W-1:0]  pos;
   logic [LEN_W-1:0]  len_raw;
   logic [FLEN_W-1:0] len;
   logic [POS_W-1:0]  top_idx;
   logic [WIDTH-1:0]  low_mask;
   logic [WIDTH-1:0]  ins_mask;
   logic [WIDTH-1:0]  ins_val;
   logic [WIDTH-1:0]  ins_q;
   logic [WIDTH-1:0]  shifted;
   logic [WIDTH-1:0]  fld;
   logic [WIDTH-1:0]  sext_q;

   assign pos      = desc[POS_W-1:0];
   assign len_raw  = desc[POS_W +: LEN_W];
   assign len      = (len_raw == '0) ? FLEN_W'(ZERO_LEN) : FLEN_W'(len_raw);
   assign top_idx  = POS_W'(len - FLEN_W'(1));
   assign low_mask = ~({WIDTH{1'b1}} << len);

   assign ins_mask = low_mask << pos;
   assign ins_val  = WIDTH'(src) << pos;
   assign ins_q    = (a & ~ins_mask) | (ins_val & ins_mask);

   assign shifted  = a >> pos;
   assign fld      = shifted & low_mask;
   assign sext_q   = shifted[top_idx] ? (fld | ~low_mask) : fld;

   always_comb begin
      unique case (op)
         OP_FINS: res = ins_q;
         OP_FEXS: res = sext_q;
         OP_FEXU: res = fld;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/bfalu_flip.sv
module bfalu_flip #(
   parameter int WIDTH  = 32,
   localparam int STG_N = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] a,
   input  logic [STG_N-1:0] sel,
   output logic [WIDTH-1:0] res
);
   logic [WIDTH-1:0] stage [STG_N+1];

   assign stage[0] = a;

   for (genvar k = 0; k < STG_N; k++) begin : g_stage
      logic [WIDTH-1:0] swapped;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         localparam int PARTNER = i ^ (1 << k);
         assign swapped[i] = stage[k][PARTNER];
      end
      assign stage[k+1] = sel[k] ? swapped : stage[k];
   end

   assign res = stage[STG_N];
endmodule

// File: rtl/bfalu.sv
module bfalu
   import bfalu_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter int LEN_W        = 4,
   parameter int ZERO_LEN     = 16,
   parameter int INS_SHIFT    = 10,
   parameter int APPEND_W     = 10,
   parameter bit SHARED_ADDER = 1'b1,
   parameter bit ROT_DOUBLE   = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [3:0]       op,
   output logic [WIDTH-1:0] result,
   output logic             illegal
);
   localparam int POS_W  = $clog2(WIDTH);
   localparam int DESC_W = POS_W + LEN_W;

   if (WIDTH != (1 << POS_W)) begin : g_chk_pow2
      $error("bfalu: WIDTH must be a power of two");
   end
   if (DESC_W > INS_SHIFT) begin : g_chk_desc
      $error("bfalu: field descriptor overlaps insert source");
   end
   if (ZERO_LEN < 1 || ZERO_LEN > WIDTH) begin : g_chk_zlen
      $error("bfalu: ZERO_LEN out of range");
   end
   if (APPEND_W >= WIDTH) begin : g_chk_apnd
      $error("bfalu: APPEND_W too large");
   end

   bfalu_op_e        op_e;
   bfalu_unit_e      unit;
   logic [WIDTH-1:0] arith_res;
   logic [WIDTH-1:0] shift_res;
   logic [WIDTH-1:0] field_res;
   logic [WIDTH-1:0] flip_res;

   assign op_e = bfalu_op_e'(op);

   always_comb begin
      unique case (op_e)
         OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_XNOR: unit = UNIT_ARITH;
         OP_ROR, OP_SLL, OP_SRL, OP_SRA, OP_APND:        unit = UNIT_SHIFT;
         OP_FINS, OP_FEXS, OP_FEXU:                      unit = UNIT_FIELD;
         OP_FLIP:                                        unit = UNIT_FLIP;
         default:                                        unit = UNIT_NONE;
      endcase
   end

   bfalu_arith #(.WIDTH(WIDTH), .SHARED_ADDER(SHARED_ADDER)) u_arith (
      .a(a), .b(b), .op(op_e), .res(arith_res)
   );

   bfalu_shift #(.WIDTH(WIDTH), .APPEND_W(APPEND_W), .ROT_DOUBLE(ROT_DOUBLE)) u_shift (
      .a(a), .amt(b[POS_W-1:0]), .imm(b[APPEND_W-1:0]), .op(op_e), .res(shift_res)
   );

   bfalu_field #(.WIDTH(WIDTH), .LEN_W(LEN_W), .ZERO_LEN(ZERO_LEN), .INS_SHIFT(INS_SHIFT)) u_field (
      .a(a), .desc(b[DESC_W-1:0]), .src(b[WIDTH-1:INS_SHIFT]), .op(op_e), .res(field_res)
   );

   bfalu_flip #(.WIDTH(WIDTH)) u_flip (
      .a(a), .sel(b[POS_W-1:0]), .res(flip_res)
   );

   always_comb begin
      illegal = 1'b0;
      unique case (unit)
         UNIT_ARITH: result = arith_res;
         UNIT_SHIFT: result = shift_res;
         UNIT_FIELD: result = field_res;
         UNIT_FLIP:  result = flip_res;
         default: begin
            result  = '0;
            illegal = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/bfalu_chk.sv
module bfalu_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic [3:0]       op,
   input logic [WIDTH-1:0] result,
   input logic             illegal
);
   logic [WIDTH-1:0] fmask;
   logic [WIDTH-1:0] umask;
   int               flen;

   always_comb begin
      flen = int'(b[8:5]);
      if (flen == 0) flen = 16;
      fmask = '0;
      umask = '0;
      for (int j = 0; j < 16; j++) begin
         if (j < flen) begin
            umask[j] = 1'b1;
            if (int'(b[4:0]) + j < WIDTH) fmask[int'(b[4:0]) + j] = 1'b1;
         end
      end
   end

   always_comb begin
      if (!$isunknown({a, b, op, result, illegal})) begin
         AST_ILLEGAL_ZERO: assert (!illegal || result == '0);                                  // R11
         AST_ILLEGAL_CODE: assert (illegal == (op == 4'hF));                                   // R11
         AST_AND_SUBSET:   assert (op != 4'h4 || (result & ~a) == '0);                          // R2
         AST_ROT_POP:      assert (op != 4'h1 || $countones(result) == $countones(a));          // R4
         AST_FLIP_POP:     assert (op != 4'hE || $countones(result) == $countones(a));          // R10
         AST_APPEND_LOW:   assert (op != 4'h3 || result[9:0] == b[9:0]);                        // R5
         AST_INSERT_KEEP:  assert (op != 4'hB || ((result ^ a) & ~fmask) == '0);                // R7
         AST_UEXT_UPPER:   assert (op != 4'hD || (result & ~umask) == '0);                      // R9
      end
   end
endmodule

bind bfalu bfalu_chk #(.WIDTH(WIDTH)) u_bfalu_chk (
   .a(a), .b(b), .op(op), .result(result), .illegal(illegal)
);

// File: tb/bfalu_bench.sv
module bfalu_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] a   = '0;
   logic [31:0] b   = '0;
   logic [3:0]  op  = '0;
   logic [31:0] result;
   logic        illegal;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   bfalu u_bfalu (
      .a(a), .b(b), .op(op), .result(result), .illegal(illegal)
   );

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   task automatic apply(logic [3:0] o, logic [31:0] x, logic [31:0] y);
      @(negedge clk);
      op = o; a = x; b = y;
      #1;
   endtask

   function automatic logic [31:0] fdesc(logic [21:0] src, int len, int pos);
      return {src, 1'b0, 4'(len), 5'(pos)};
   endfunction

   function automatic int flen_of(logic [31:0] y);
      return (y[8:5] == 0) ? 16 : int'(y[8:5]);
   endfunction

   function automatic logic [31:0] ref_ror(logic [31:0] x, int n);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = x[(i + n) % 32];
      return r;
   endfunction

   function automatic logic [31:0] ref_sra(logic [31:0] x, int n);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? x[i + n] : x[31];
      return r;
   endfunction

   function automatic logic [31:0] ref_ins(logic [31:0] x, logic [31:0] y);
      logic [31:0] r = x;
      int pos = int'(y[4:0]);
      for (int j = 0; j < flen_of(y); j++)
         if (pos + j < 32) r[pos + j] = y[10 + j];
      return r;
   endfunction

   function automatic logic [31:0] ref_ext(logic [31:0] x, logic [31:0] y, bit sgn);
      logic [31:0] r = '0;
      int pos = int'(y[4:0]);
      int len = flen_of(y);
      for (int j = 0; j < len; j++) r[j] = (pos + j < 32) ? x[pos + j] : 1'b0;
      if (sgn) for (int j = len; j < 32; j++) r[j] = r[len - 1];
      return r;
   endfunction

   function automatic logic [31:0] ref_flip(logic [31:0] x, logic [4:0] s);
      logic [31:0] r = x;
      logic [31:0] t;
      for (int k = 0; k < 5; k++)
         if (s[k]) begin
            for (int i = 0; i < 32; i++) t[i] = r[i ^ (1 << k)];
            r = t;
         end
      return r;
   endfunction

   task automatic t_reset_idle;
      apply(4'h0, 32'h0, 32'h0);
      chk("R1 idle result", result, 32'h0);
      chk("R11 idle flag", {31'b0, illegal}, 32'h0);
   endtask

   task automatic t_arith;
      apply(4'h0, 32'hFFFF_FFFF, 32'h0000_0002);
      chk("R1 add wrap", result, 32'h0000_0001);
      apply(4'h0, 32'h1234_5678, 32'h1111_1111);
      chk("R1 add", result, 32'h2345_6789);
      apply(4'h2, 32'h0000_0001, 32'h0000_0003);
      chk("R1 sub wrap", result, 32'hFFFF_FFFE);
   endtask

   task automatic t_logic;
      logic [31:0] x = 32'hF0F0_33CC;
      logic [31:0] y = 32'h0FF0_5A5A;
      apply(4'h4, x, y); chk("R2 and", result, x & y);
      apply(4'h5, x, y); chk("R2 or", result, x | y);
      apply(4'h6, x, y); chk("R2 xor", result, x ^ y);
      apply(4'h7, x, y); chk("R2 xnor", result, ~(x ^ y));
   endtask

   task automatic t_shifts;
      logic [31:0] x = 32'h8123_4567;
      apply(4'h8, x, 32'hFFFF_FFE4); chk("R3 sll upper b ignored", result, x << 4);
      apply(4'h9, x, 32'h0000_0021); chk("R3 srl amount 33->1", result, x >> 1);
      apply(4'hA, x, 32'h0000_0008); chk("R3 sra neg", result, ref_sra(x, 8));
      apply(4'hA, 32'h4000_0000, 32'h0000_001F); chk("R3 sra pos", result, 32'h0);
   endtask

   task automatic t_rotate;
      logic [31:0] x = 32'hDEAD_BEEF;
      apply(4'h1, x, 32'h0000_0000); chk("R4 ror 0", result, x);
      apply(4'h1, x, 32'hFFFF_FF25); chk("R4 ror 5 upper ignored", result, ref_ror(x, 5));
      apply(4'h1, x, 32'h0000_001F); chk("R4 ror 31", result, ref_ror(x, 31));
   endtask

   task automatic t_append;
      apply(4'h3, 32'hFFC0_0ABC, 32'hFFFF_F3A5);
      chk("R5 append", result, {22'h00_0ABC, 10'h3A5});
   endtask

   task automatic t_field_len;
      logic [31:0] y = fdesc(22'h0, 0, 4);
      apply(4'hD, 32'h89AB_CDEF, y);
      chk("R6 len0 means 16", result, 32'h0000_BCDE);
      y = fdesc(22'h0, 15, 0);
      apply(4'hD, 32'h89AB_CDEF, y);
      chk("R6 len15", result, 32'h0000_4DEF);
   endtask

   task automatic t_insert;
      logic [31:0] y = fdesc(22'h3FF5, 4, 8);
      apply(4'hB, 32'h1234_5678, y); chk("R7 insert mid", result, 32'h1234_5578);
      y = fdesc(22'h2ABC, 8, 28);
      apply(4'hB, 32'h1234_5678, y); chk("R7 insert clipped", result, ref_ins(32'h1234_5678, y));
      y = fdesc(22'h1234, 0, 16);
      apply(4'hB, 32'hFFFF_FFFF, y); chk("R7 insert len16", result, 32'h1234_FFFF);
   endtask

   task automatic t_extract;
      logic [31:0] y = fdesc(22'h0, 8, 4);
      apply(4'hC, 32'h0000_0F80, y); chk("R8 sext neg", result, 32'hFFFF_FFF8);
      apply(4'hC, 32'h0000_0700, y); chk("R8 sext pos", result, 32'h0000_0070);
      y = fdesc(22'h0, 8, 28);
      apply(4'hC, 32'hF000_0000, y); chk("R8 sext beyond top", result, ref_ext(32'hF000_0000, y, 1'b1));
      y = fdesc(22'h0, 8, 4);
      apply(4'hD, 32'h0000_0F80, y); chk("R9 zext", result, 32'h0000_00F8);
      y = fdesc(22'h0, 3, 29);
      apply(4'hD, 32'hE000_0000, y); chk("R9 zext top", result, ref_ext(32'hE000_0000, y, 1'b0));
   endtask

   task automatic t_flip;
      logic [31:0] x = 32'h1234_5678;
      apply(4'hE, x, 32'h0000_0000); chk("R10 flip none", result, x);
      apply(4'hE, x, 32'h0000_0018); chk("R10 flip bytes+halves", result, 32'h7856_3412);
      apply(4'hE, x, 32'hFFFF_FFFF); chk("R10 flip all reverses", result, {<<{x}});
      apply(4'hE, x, 32'h0000_0005); chk("R10 flip bits+nibbles", result, ref_flip(x, 5'h05));
      apply(4'hE, 32'h8000_0001, 32'h0000_0002); chk("R10 flip pairs", result, 32'h2000_0004);
   endtask

   task automatic t_illegal;
      apply(4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      chk("R11 illegal flag", {31'b0, illegal}, 32'h1);
      chk("R11 illegal result", result, 32'h0);
      apply(4'hE, 32'h1, 32'h1);
      chk("R11 flag low for flip", {31'b0, illegal}, 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_reset_idle();
      t_arith();
      t_logic();
      t_shifts();
      t_rotate();
      t_append();
      t_field_len();
      t_insert();
      t_extract();
      t_flip();
      t_illegal();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule